// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a processor core that finishes one instruction on every clock edge. It covers a small subset of a fixed-width 32-bit instruction set with three encodings. In one cycle it fetches the word at the program counter and decodes the opcode into datapath controls. It reads two registers, runs the ALU and touches data memory. It then writes a result back and picks the next program counter. The core holds its own word-addressed instruction and data memories. A bench or boot agent fills them through a write-only load stream while the core is held in reset.

The load stream is a valid/ready interface. `ld_ready` is high only while `rst` is high, so the agent sees back-pressure for the whole time the core runs. A word is written when `ld_valid` and `ld_ready` are both high on a rising edge. An offer made while the core runs is held off and has no effect. A combinational peek port reads any data memory word. The commit outputs show, in the cycle an instruction executes, its program counter, its register write and its memory store.

Top module: `rcore_top`

## Requirements
- R1: `rst` is synchronous and active high. The edge that samples it sets the program counter to 0. While `rst` is high, `ld_ready` is 1 and `wb_en` and `st_en` are 0. While `rst` is low, `ld_ready` is 0 and a load offer writes nothing.
- R2: On an edge with `ld_valid` and `ld_ready` both high, `ld_data` is written to word `ld_addr` of one memory: instruction memory when `ld_sel`=0, data memory when `ld_sel`=1. `peek_data` returns data memory word `peek_addr` combinationally.
- R3: Opcode 0 with a zero shift field [10:6] writes an ALU result to register rd [15:11], from sources rs [25:21] and rt [20:16]. The function field [5:0] selects the operation: 0x20 add, 0x22 rs-rt, 0x24 AND, 0x25 OR, 0x2A signed less-than giving 1 or 0.
- R4: Opcode 0x08 writes rs + sext(imm) to rt. sext copies bit 15 of imm [15:0] into bits 31..16.
- R5: Opcode 0x23 loads data memory word (rs+sext(imm))[DMEM_AW+1:2] into rt. Opcode 0x2B stores rt at that address and writes no register. The store shows on `st_en`/`st_addr`/`st_val` in its own cycle.
- R6: Opcode 0x04 sets the next PC to PC+4+(sext(imm)<<2) when rs equals rt, and to PC+4 otherwise.
- R7: Opcode 0x05 takes the same target when rs differs from rt, and goes to PC+4 otherwise.
- R8: Opcode 0x02 sets the next PC to {(PC+4)[31:28], instr[25:0], 2'b00}.
- R9: Register 0 always reads as 0. A write aimed at it is dropped, and `wb_en` stays 0 for that instruction.
- R10: Any other opcode (for example 0x03 or 0x3F) writes nothing and advances the PC by 4. So does opcode 0 with an unlisted function or a nonzero shift field.
- R11: Each cycle `pc_o` is the address of the instruction executing. `wb_en`/`wb_idx`/`wb_val` show its register write, which lands on the next edge. Any instruction other than 0x02, 0x04 and 0x05 moves the PC to PC+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ld_valid | input | 1 | Load stream word offered |
| ld_ready | output | 1 | Load stream accepts (high only in reset) |
| ld_sel | input | 1 | Load target: 0 instruction memory, 1 data memory |
| ld_addr | input | LD_AW | Word index for the load |
| ld_data | input | 32 | Word to load |
| peek_addr | input | DMEM_AW | Data memory word index to read |
| peek_data | output | 32 | Data memory word at peek_addr |
| pc_o | output | 32 | Address of the executing instruction |
| wb_en | output | 1 | Register write committed this cycle |
| wb_idx | output | 5 | Destination register |
| wb_val | output | 32 | Value written |
| st_en | output | 1 | Data memory store this cycle |
| st_addr | output | 32 | Store byte address |
| st_val | output | 32 | Store data |

## Verification
The bound checker checks several rules on every cycle. Reset forces the program counter to zero and silences both write paths. Straight-line instructions step by four, and taken equal and not-equal branches and jumps land on their computed targets. A store always carries rs plus the offset and the rt value. A zero source field always reads zero. Only the bench's program can show the values themselves. It runs every function code over signed operand pairs and compares each result against an arithmetic reference model. Untaken branches, backward loops and dropped writes to register 0 are checked the same way. So are data that reached memory through the load stream and offers refused while the core ran.

// File: rtl/rcore_pkg.sv
package rcore_pkg;

  localparam logic [5:0] OPC_REG  = 6'h00;
  localparam logic [5:0] OPC_JMP  = 6'h02;
  localparam logic [5:0] OPC_BEQ  = 6'h04;
  localparam logic [5:0] OPC_BNE  = 6'h05;
  localparam logic [5:0] OPC_ADDI = 6'h08;
  localparam logic [5:0] OPC_LDW  = 6'h23;
  localparam logic [5:0] OPC_STW  = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [3:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_ADD = 4'b0010,
    ALU_SUB = 4'b0110,
    ALU_SLT = 4'b0111
  } alu_sel_e;

  typedef enum logic [1:0] {
    AMODE_ADD   = 2'b00,
    AMODE_SUB   = 2'b01,
    AMODE_FIELD = 2'b10
  } alu_mode_e;

  typedef struct packed {
    logic      dst_rd;
    logic      branch;
    logic      br_on_ne;
    logic      jump;
    logic      mem_rd;
    logic      mem_to_reg;
    logic      mem_wr;
    logic      src_imm;
    logic      reg_wr;
    alu_mode_e alu_mode;
  } ctrl_t;

  function automatic logic [31:0] sext16(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

endpackage

// File: rtl/rcore_decode.sv
module rcore_decode
  import rcore_pkg::*;
(
  input  logic [5:0] opcode,
  output ctrl_t      ctl
);
  always_comb begin
    ctl = '0;
    ctl.alu_mode = AMODE_ADD;
    case (opcode)
      OPC_REG: begin
        ctl.dst_rd   = 1'b1;
        ctl.reg_wr   = 1'b1;
        ctl.alu_mode = AMODE_FIELD;
      end
      OPC_ADDI: begin
        ctl.src_imm = 1'b1;
        ctl.reg_wr  = 1'b1;
      end
      OPC_LDW: begin
        ctl.src_imm    = 1'b1;
        ctl.mem_rd     = 1'b1;
        ctl.mem_to_reg = 1'b1;
        ctl.reg_wr     = 1'b1;
      end
      OPC_STW: begin
        ctl.src_imm = 1'b1;
        ctl.mem_wr  = 1'b1;
      end
      OPC_BEQ: begin
        ctl.branch   = 1'b1;
        ctl.alu_mode = AMODE_SUB;
      end
      OPC_BNE: begin
        ctl.branch   = 1'b1;
        ctl.br_on_ne = 1'b1;
        ctl.alu_mode = AMODE_SUB;
      end
      OPC_JMP: ctl.jump = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/rcore_aluctl.sv
module rcore_aluctl
  import rcore_pkg::*;
(
  input  alu_mode_e  mode,
  input  logic [5:0] funct,
  input  logic [4:0] shamt,
  output alu_sel_e   sel,
  output logic       valid
);
  always_comb begin
    sel   = ALU_ADD;
    valid = 1'b1;
    case (mode)
      AMODE_ADD: sel = ALU_ADD;
      AMODE_SUB: sel = ALU_SUB;
      AMODE_FIELD: begin
        case (funct)
          FN_ADD:  sel = ALU_ADD;
          FN_SUB:  sel = ALU_SUB;
          FN_AND:  sel = ALU_AND;
          FN_OR:   sel = ALU_OR;
          FN_SLT:  sel = ALU_SLT;
          default: valid = 1'b0;
        endcase
        if (shamt != 5'd0) valid = 1'b0;
      end
      default: valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/rcore_alu.sv
module rcore_alu
  import rcore_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_sel_e     sel,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    case (sel)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = ($signed(a) < $signed(b)) ? W'(1) : '0;
      default: y = '0;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/rcore_regfile.sv
module rcore_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int RAW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           we,
  input  logic [RAW-1:0] waddr,
  input  logic [W-1:0]   wdata,
  input  logic [RAW-1:0] raddr_a,
  input  logic [RAW-1:0] raddr_b,
  output logic [W-1:0]   rdata_a,
  output logic [W-1:0]   rdata_b
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we && waddr != '0) regs[waddr] <= wdata;
  end

  assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];
endmodule

// File: rtl/rcore_ram.sv
module rcore_ram #(
  parameter int W   = 32,
  parameter int AW  = 6,
  parameter int NRD = 1,
  localparam int DEPTH = 1 << AW
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic [W-1:0]            wdata,
  input  logic [NRD-1:0][AW-1:0]  raddr,
  output logic [NRD-1:0][W-1:0]   rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = mem[raddr[p]];
  end
endmodule

// File: rtl/rcore_top.sv
module rcore_top
  import rcore_pkg::*;
#(
  parameter int IMEM_AW = 8,
  parameter int DMEM_AW = 6,
  localparam int LD_AW  = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ld_valid,
  output logic               ld_ready,
  input  logic               ld_sel,
  input  logic [LD_AW-1:0]   ld_addr,
  input  logic [31:0]        ld_data,
  input  logic [DMEM_AW-1:0] peek_addr,
  output logic [31:0]        peek_data,
  output logic [31:0]        pc_o,
  output logic               wb_en,
  output logic [4:0]         wb_idx,
  output logic [31:0]        wb_val,
  output logic               st_en,
  output logic [31:0]        st_addr,
  output logic [31:0]        st_val
);
  localparam int XLEN = 32;
  localparam int NREG = 32;

  logic [XLEN-1:2] pc_q;
  logic [XLEN-1:0] pc, pc4, br_tgt, jmp_tgt, pc_nxt;
  logic [XLEN-1:0] instr, imm_x, rs_val, rt_val, alu_b, alu_y, ld_word;
  logic [XLEN-1:0] dm_rd;
  logic            ld_fire, alu_zero, fn_ok, br_take, core_st;
  ctrl_t           ctl;
  alu_sel_e        alu_sel;

  // load stream: accepted only while the core is held in reset
  assign ld_ready = rst;
  assign ld_fire  = ld_valid & ld_ready;

  // program counter
  assign pc = {pc_q, 2'b00};
  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_nxt[XLEN-1:2];
  end

  // instruction memory
  logic [0:0][IMEM_AW-1:0] im_ra;
  logic [0:0][XLEN-1:0]    im_rd;
  assign im_ra[0] = pc[IMEM_AW+1:2];
  assign instr    = im_rd[0];

  rcore_ram #(.W(XLEN), .AW(IMEM_AW), .NRD(1)) u_imem (
    .clk   (clk),
    .we    (ld_fire & ~ld_sel),
    .waddr (ld_addr[IMEM_AW-1:0]),
    .wdata (ld_data),
    .raddr (im_ra),
    .rdata (im_rd)
  );

  // decode
  rcore_decode u_dec (
    .opcode (instr[31:26]),
    .ctl    (ctl)
  );

  rcore_aluctl u_aluctl (
    .mode  (ctl.alu_mode),
    .funct (instr[5:0]),
    .shamt (instr[10:6]),
    .sel   (alu_sel),
    .valid (fn_ok)
  );

  // registers
  assign wb_idx = ctl.dst_rd ? instr[15:11] : instr[20:16];
  assign wb_en  = ctl.reg_wr & fn_ok & ~rst & (wb_idx != 5'd0);

  rcore_regfile #(.W(XLEN), .NREG(NREG)) u_rf (
    .clk     (clk),
    .we      (wb_en),
    .waddr   (wb_idx),
    .wdata   (wb_val),
    .raddr_a (instr[25:21]),
    .raddr_b (instr[20:16]),
    .rdata_a (rs_val),
    .rdata_b (rt_val)
  );

  // execute
  assign imm_x = sext16(instr[15:0]);
  assign alu_b = ctl.src_imm ? imm_x : rt_val;

  rcore_alu #(.W(XLEN)) u_alu (
    .a    (rs_val),
    .b    (alu_b),
    .sel  (alu_sel),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // data memory: load stream in reset, core stores otherwise
  logic [1:0][DMEM_AW-1:0] dm_ra;
  logic [1:0][XLEN-1:0]    dm_rdv;
  logic                    dm_we;
  logic [DMEM_AW-1:0]      dm_wa;
  logic [XLEN-1:0]         dm_wd;

  assign core_st  = ctl.mem_wr & ~rst;
  assign dm_we    = (ld_fire & ld_sel) | core_st;
  assign dm_wa    = ld_fire ? ld_addr[DMEM_AW-1:0] : alu_y[DMEM_AW+1:2];
  assign dm_wd    = ld_fire ? ld_data : rt_val;
  assign dm_ra[0] = alu_y[DMEM_AW+1:2];
  assign dm_ra[1] = peek_addr;
  assign dm_rd    = dm_rdv[0];
  assign peek_data = dm_rdv[1];

  rcore_ram #(.W(XLEN), .AW(DMEM_AW), .NRD(2)) u_dmem (
    .clk   (clk),
    .we    (dm_we),
    .waddr (dm_wa),
    .wdata (dm_wd),
    .raddr (dm_ra),
    .rdata (dm_rdv)
  );

  // write-back
  assign ld_word = ctl.mem_rd ? dm_rd : '0;
  assign wb_val  = ctl.mem_to_reg ? ld_word : alu_y;

  // next program counter
  assign pc4     = pc + 32'd4;
  assign br_tgt  = pc4 + {imm_x[XLEN-3:0], 2'b00};
  assign jmp_tgt = {pc4[31:28], instr[25:0], 2'b00};
  assign br_take = ctl.branch & (alu_zero ^ ctl.br_on_ne);

  always_comb begin
    if (ctl.jump)      pc_nxt = jmp_tgt;
    else if (br_take)  pc_nxt = br_tgt;
    else               pc_nxt = pc4;
  end

  // commit view
  assign pc_o    = pc;
  assign st_en   = core_st;
  assign st_addr = alu_y;
  assign st_val  = rt_val;
endmodule

// File: rtl/rcore_chk.sv
module rcore_chk (
  input logic        clk,
  input logic        rst,
  input logic        ld_ready,
  input logic [31:0] pc_o,
  input logic [31:0] instr,
  input logic [31:0] rs_val,
  input logic [31:0] rt_val,
  input logic        wb_en,
  input logic        st_en,
  input logic [31:0] st_addr,
  input logic [31:0] st_val
);
  logic seen = 1'b0;
  logic prev_rst = 1'b0;
  logic [5:0]  op;
  logic [31:0] offs;
  logic        ctl_flow;

  assign op       = instr[31:26];
  assign offs     = {{16{instr[15]}}, instr[15:0]};
  assign ctl_flow = (op == 6'h02) || (op == 6'h04) || (op == 6'h05);

  always @(posedge clk) begin
    // R1
    if (seen && prev_rst) pc_reset_chk: assert (pc_o == 32'd0)
      else $error("pc not cleared by reset");
    // R1
    if (rst) quiet_reset_chk: assert (!wb_en && !st_en && ld_ready)
      else $error("writes or closed load port during reset");
    prev_rst <= rst;
    seen     <= 1'b1;
  end

  // R9
  zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (instr[25:21] == 5'd0) |-> (rs_val == 32'd0));

  // R11
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl_flow |=> (pc_o == $past(pc_o) + 32'd4));

  // R6
  beq_tgt_chk: assert property (@(posedge clk) disable iff (rst)
    (op == 6'h04 && rs_val == rt_val) |=>
      (pc_o == $past(pc_o + 32'd4 + {offs[29:0], 2'b00})));

  // R7
  bne_tgt_chk: assert property (@(posedge clk) disable iff (rst)
    (op == 6'h05 && rs_val != rt_val) |=>
      (pc_o == $past(pc_o + 32'd4 + {offs[29:0], 2'b00})));

  // R8
  jump_tgt_chk: assert property (@(posedge clk) disable iff (rst)
    (op == 6'h02) |=>
      (pc_o == $past({pc_o[31:28] + {3'b000, (pc_o[27:0] > 28'hFFFFFFB)}, instr[25:0], 2'b00})));

  // R5
  store_chk: assert property (@(posedge clk) disable iff (rst)
    st_en |-> (st_addr == rs_val + offs && st_val == rt_val));
endmodule

bind rcore_top rcore_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .ld_ready (ld_ready),
  .pc_o     (pc_o),
  .instr    (instr),
  .rs_val   (rs_val),
  .rt_val   (rt_val),
  .wb_en    (wb_en),
  .st_en    (st_en),
  .st_addr  (st_addr),
  .st_val   (st_val)
);

// File: tb/test_rcore_top.sv
module test_rcore_top;
  localparam int CLK_PERIOD = 10;
  localparam int IMEM_AW = 8;
  localparam int DMEM_AW = 6;
  localparam int LD_AW = 8;

  logic clk = 1'b0;
  logic rst, ld_valid, ld_ready, ld_sel;
  logic [LD_AW-1:0]   ld_addr;
  logic [31:0]        ld_data, peek_data, pc_o, wb_val, st_addr, st_val;
  logic [DMEM_AW-1:0] peek_addr;
  logic               wb_en, st_en;
  logic [4:0]         wb_idx;

  rcore_top #(.IMEM_AW(IMEM_AW), .DMEM_AW(DMEM_AW)) i_rcore_top (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_sel(ld_sel), .ld_addr(ld_addr), .ld_data(ld_data),
    .peek_addr(peek_addr), .peek_data(peek_data), .pc_o(pc_o),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_val(wb_val),
    .st_en(st_en), .st_addr(st_addr), .st_val(st_val)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_err = 0;

  logic [31:0] prog [256];
  logic [31:0] mr [32];
  logic [31:0] md [64];
  logic [31:0] mpc;
  int np = 0;
  int halt_idx;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rd, input int rs, input int rt);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rt, input int rs, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] enc_j(input int tgt);
    return {6'h02, 26'(tgt)};
  endfunction

  task automatic emit(input logic [31:0] w);
    prog[np] = w;
    np++;
  endtask

  // reference model: checks the current cycle, then advances
  task automatic model_cycle();
    logic [31:0] ins, sx, a, b, val, addr, npc;
    logic [5:0]  op, fn;
    logic [4:0]  rs, rt, rd, sh, idx;
    logic        e_wb, e_st;
    string       tpc, twb;
    ins = prog[mpc[9:2]];
    op = ins[31:26]; rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
    sh = ins[10:6];  fn = ins[5:0];
    sx = {{16{ins[15]}}, ins[15:0]};
    a = (rs == 0) ? 32'd0 : mr[rs];
    b = (rt == 0) ? 32'd0 : mr[rt];
    e_wb = 1'b0; e_st = 1'b0; idx = 5'd0; val = 32'd0; addr = a + sx;
    npc = mpc + 32'd4; tpc = "R11"; twb = "R10";
    case (op)
      6'h00: if (sh == 0) begin
        e_wb = 1'b1; idx = rd; twb = "R3";
        case (fn)
          6'h20: val = a + b;
          6'h22: val = a - b;
          6'h24: val = a & b;
          6'h25: val = a | b;
          6'h2A: val = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          default: begin e_wb = 1'b0; twb = "R10"; end
        endcase
      end
      6'h08: begin e_wb = 1'b1; idx = rt; val = a + sx; twb = "R4"; end
      6'h23: begin e_wb = 1'b1; idx = rt; val = md[addr[7:2]]; twb = "R5"; end
      6'h2B: begin e_st = 1'b1; twb = "R5"; end
      6'h04: begin tpc = "R6"; if (a == b) npc = mpc + 32'd4 + {sx[29:0], 2'b00}; end
      6'h05: begin tpc = "R7"; if (a != b) npc = mpc + 32'd4 + {sx[29:0], 2'b00}; end
      6'h02: begin tpc = "R8"; npc = {mpc[31:28], ins[25:0], 2'b00}; end
      default: ;
    endcase
    if (e_wb && idx == 0) begin e_wb = 1'b0; twb = "R9"; end
    chk(tpc, "pc", pc_o, mpc);
    chk(twb, "wb_en", 32'(wb_en), 32'(e_wb));
    if (e_wb) begin
      chk(twb, "wb_idx", 32'(wb_idx), 32'(idx));
      chk(twb, "wb_val", wb_val, val);
    end
    chk("R5", "st_en", 32'(st_en), 32'(e_st));
    if (e_st) begin
      chk("R5", "st_addr", st_addr, addr);
      chk("R5", "st_val", st_val, b);
    end
    if (e_wb) mr[idx] = val;
    if (e_st) md[addr[7:2]] = b;
    mpc = npc;
  endtask

  task automatic load_word(input logic sel, input int addr, input logic [31:0] data);
    ld_valid = 1'b1; ld_sel = sel; ld_addr = LD_AW'(addr); ld_data = data;
    @(posedge clk); #1;
    ld_valid = 1'b0;
  endtask

  task automatic build_program();
    int srcs [4] = '{1, 2, 4, 5};
    logic [5:0] fns [5] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h2A};
    int k = 0;
    int tgt;
    emit(enc_i(6'h08, 1, 0, 16'h0005));
    emit(enc_i(6'h08, 2, 0, 16'hFFFB));
    emit(enc_i(6'h08, 3, 0, 16'h7FFF));
    emit(enc_i(6'h08, 4, 0, 16'h8000));
    emit(enc_i(6'h08, 5, 1, 16'hFFFB));
    emit(enc_i(6'h08, 6, 3, 16'h7FFF));
    // R3 sweep: every function over every operand pair
    for (int f = 0; f < 5; f++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++) begin
          emit(enc_r(fns[f], 8 + (k % 16), srcs[i], srcs[j]));
          k++;
        end
    // R9 writes to register 0
    emit(enc_i(6'h08, 0, 1, 16'h0007));
    emit(enc_r(6'h20, 0, 1, 1));
    emit(enc_r(6'h20, 24, 0, 0));
    // R10 unknown encodings
    emit(enc_r(6'h21, 25, 1, 2));
    emit(enc_r(6'h20, 25, 1, 2) | 32'h0000_0040);
    emit({6'h3F, 26'h3FF_FFFF});
    emit({6'h03, 26'h000_0004});
    // R5 memory, negative and positive offsets, preloaded word
    emit(enc_i(6'h08, 26, 0, 16'd40));
    emit(enc_i(6'h2B, 2, 26, 16'hFFFC));
    emit(enc_i(6'h2B, 3, 26, 16'd8));
    emit(enc_i(6'h23, 27, 26, 16'hFFFC));
    emit(enc_i(6'h23, 28, 26, 16'd0));
    // R6 / R7 taken and not taken
    emit(enc_i(6'h04, 1, 1, 16'd1));
    emit(enc_i(6'h08, 29, 0, 16'd99));
    emit(enc_i(6'h04, 2, 1, 16'd1));
    emit(enc_i(6'h08, 29, 0, 16'd11));
    emit(enc_i(6'h05, 2, 1, 16'd1));
    emit(enc_i(6'h08, 30, 0, 16'd99));
    emit(enc_i(6'h05, 0, 5, 16'd1));
    emit(enc_i(6'h08, 30, 0, 16'd12));
    // backward loop
    emit(enc_i(6'h08, 31, 0, 16'd3));
    emit(enc_i(6'h08, 31, 31, 16'hFFFF));
    emit(enc_i(6'h05, 0, 31, 16'hFFFE));
    // R8 forward jump over a poisoned write
    tgt = np + 2;
    emit(enc_j(tgt));
    emit(enc_i(6'h08, 29, 0, 16'd77));
    emit(enc_i(6'h2B, 30, 0, 16'd0));
    halt_idx = np;
    emit(enc_j(halt_idx));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_err++;
    $display("FAIL watchdog: got hung expected finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    rst = 1'b1; ld_valid = 1'b0; ld_sel = 1'b0; ld_addr = '0; ld_data = '0;
    peek_addr = '0;
    for (int r = 0; r < 32; r++) mr[r] = 32'd0;
    for (int w = 0; w < 64; w++) md[w] = 32'd0;
    repeat (2) @(posedge clk);
    #1;
    @(negedge clk);
    chk("R1", "ld_ready in reset", 32'(ld_ready), 32'd1);
    chk("R1", "wb_en in reset", 32'(wb_en), 32'd0);
    chk("R1", "st_en in reset", 32'(st_en), 32'd0);
    chk("R1", "pc in reset", pc_o, 32'd0);
    @(posedge clk); #1;

    build_program();
    for (int i = 0; i < np; i++) load_word(1'b0, i, prog[i]);
    load_word(1'b1, 10, 32'hCAFE_BABE); md[10] = 32'hCAFE_BABE;
    load_word(1'b1, 50, 32'h1111_1111); md[50] = 32'h1111_1111;
    peek_addr = 6'd10; #1;
    chk("R2", "peek preloaded", peek_data, 32'hCAFE_BABE);

    // release reset; a load offer stays up and must be refused
    rst = 1'b0;
    ld_valid = 1'b1; ld_sel = 1'b1; ld_addr = 8'd50; ld_data = 32'h2222_2222;
    mpc = 32'd0;
    @(negedge clk);
    chk("R1", "ld_ready running", 32'(ld_ready), 32'd0);
    begin
      bit halted = 1'b0;
      for (int c = 0; c < 400 && !halted; c++) begin
        if (c != 0) @(negedge clk);
        halted = (mpc == 32'(halt_idx * 4));
        model_cycle();
      end
    end
    for (int c = 0; c < 2; c++) begin
      @(negedge clk);
      model_cycle();
    end
    ld_valid = 1'b0;

    peek_addr = 6'd9;  #1; chk("R5", "store neg offset", peek_data, 32'hFFFF_FFFB);
    peek_addr = 6'd12; #1; chk("R5", "store pos offset", peek_data, 32'h0000_7FFF);
    peek_addr = 6'd0;  #1; chk("R5", "store after jump", peek_data, md[0]);
    peek_addr = 6'd10; #1; chk("R2", "preload intact", peek_data, 32'hCAFE_BABE);
    peek_addr = 6'd50; #1; chk("R1", "refused load", peek_data, 32'h1111_1111);

    // reset again mid-run
    @(posedge clk); #1;
    rst = 1'b1;
    @(negedge clk);
    chk("R1", "wb_en re-reset", 32'(wb_en), 32'd0);
    chk("R1", "st_en re-reset", 32'(st_en), 32'd0);
    @(negedge clk);
    chk("R1", "pc re-reset", pc_o, 32'd0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule